// File: doc/BRIEF.md
# Mixed-Width Byte Data FIFO

This block is a byte-granular FIFO placed between a 32-bit host data port and a serial engine that produces or consumes one byte per cycle. The host reaches the FIFO through one data location. Each access there may be one, two or four bytes wide, and it moves exactly that many bytes. A software loop drains or fills a transfer with word accesses while at least four bytes remain. It then uses one halfword access, then one byte access, for the tail.

A direction input sets the roles of the two sides:

- **Read direction:** the engine pushes received bytes and the host pops them.
- **Write direction:** the host pushes bytes and the engine pops them for transmission.

A programmable threshold drives a pacing flag that software polls before each access. When DMA is enabled, the same condition also appears on a request output. Overflow and underflow are handled without corrupting state. Bytes that do not fit are discarded, and missing bytes read back as zero. An abort input empties the FIFO in one cycle.

Top module: `dbf_top`

## Requirements
- R1: In write direction, `host_wr` pushes 1, 2 or 4 bytes for `host_size` codes 0, 1 and 2; code 3 also moves 4 bytes; `level` rises by the number of bytes stored.
- R2: Byte order within an access is little-endian. On a push, bits 7:0 enter first. On a pop, the first byte removed lands in bits 7:0 of `host_rdata`.
- R3: The engine moves one byte per accepted cycle. `eng_out_valid` is high only in write direction with `level` > 0, and `eng_out_data` shows the oldest byte. `eng_in_ready` is high only in read direction with `level` < DEPTH.
- R4: In read direction, `host_rd` pops up to the requested width. The popped bytes appear on `host_rdata` after the clock edge, and `level` falls by the number of bytes popped.
- R5: A push never raises `level` above DEPTH. Bytes that do not fit are discarded, and the bytes already stored are not changed.
- R6: A pop asking for more bytes than are stored returns the available bytes. All other bytes of `host_rdata` are zero, and `level` stops at 0.
- R7: `thr_flag` is updated on the same edge as `level`. With threshold value T, it is high when `level` > T in read direction, or when DEPTH − `level` > T in write direction.
- R8: With the default combinational request option, `dma_req` equals `thr_flag` while `dma_en` is 1, and it is 0 while `dma_en` is 0.
- R9: In read direction, `host_wr` and `eng_out_ready` have no effect. In write direction, `eng_in_valid` and `host_rd` have no effect, and `host_rdata` holds its value.
- R10: While `abort` is high, all other accesses in that cycle are ignored. After the edge, `level`, `thr_flag` and `host_rdata` are 0.
- R11: During reset, `level`, `thr_flag`, `dma_req`, `host_rdata` and `eng_out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_rd | input | 1 | 1: engine fills and host drains; 0: host fills and engine drains |
| thresh | input | TH_W | Threshold value T for the pacing flag |
| dma_en | input | 1 | Routes the threshold condition to `dma_req` |
| abort | input | 1 | Flushes the FIFO |
| host_wr | input | 1 | Host push strobe |
| host_rd | input | 1 | Host pop strobe |
| host_size | input | SW | Access width code: 0 = byte, 1 = halfword, 2 or 3 = word |
| host_wdata | input | 8*LANES | Host push data |
| host_rdata | output | 8*LANES | Host pop data, registered |
| eng_in_valid | input | 1 | Engine byte push strobe |
| eng_in_data | input | 8 | Engine push byte |
| eng_in_ready | output | 1 | FIFO can take an engine byte |
| eng_out_valid | output | 1 | A byte is available to the engine |
| eng_out_data | output | 8 | Oldest stored byte |
| eng_out_ready | input | 1 | Engine pop strobe |
| level | output | CW | Number of bytes stored |
| thr_flag | output | 1 | Threshold-reached flag |
| dma_req | output | 1 | DMA request |

## Verification
The hardest situations to reach are the partial accesses at the edges of capacity. These are a word push that meets only three free slots, and a word pop that finds one stored byte. In both, the byte count differs from the access width, and pointers and data must stay consistent. The stimulus gets there by filling with an odd mix of word, halfword and byte pushes. It stops the FIFO exactly one byte short of the boundary, then issues a full-width access. A scoreboard queue then confirms which bytes survived and which read back as zero.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
   // host access width codes
   typedef enum logic [1:0] {
      DBF_SZ_BYTE = 2'd0,
      DBF_SZ_HALF = 2'd1,
      DBF_SZ_WORD = 2'd2,
      DBF_SZ_WIDE = 2'd3
   } dbf_size_e;

   function automatic int unsigned dbf_bytes(input int unsigned code, input int unsigned lanes);
      int unsigned lg;
      lg = $clog2(lanes);
      if (code >= lg) return lanes;
      return 1 << code;
   endfunction
endpackage

// File: rtl/dbf_arb.sv
module dbf_arb #(
   parameter int DEPTH = 16,
   parameter int LANES = 4,
   parameter int SW    = 2,
   parameter int NW    = 3,
   parameter int CW    = 5
) (
   input  logic          mode_rd,
   input  logic          abort,
   input  logic          host_wr,
   input  logic          host_rd,
   input  logic [SW-1:0] host_size,
   input  logic          eng_in_valid,
   input  logic          eng_out_ready,
   input  logic [CW-1:0] count,
   output logic [NW-1:0] push_cnt,
   output logic [NW-1:0] pop_cnt,
   output logic          host_src,
   output logic          host_pop_fire
);
   localparam int LG = $clog2(LANES);

   logic [NW-1:0] req;
   logic [CW-1:0] free_slots;

   always_comb begin
      req        = (int'(host_size) >= LG) ? NW'(LANES) : (NW'(1) << host_size);
      free_slots = CW'(DEPTH) - count;
   end

   always_comb begin
      push_cnt      = '0;
      pop_cnt       = '0;
      host_src      = !mode_rd;
      host_pop_fire = 1'b0;
      if (!abort) begin
         if (mode_rd) begin
            if (eng_in_valid && free_slots != '0) push_cnt = NW'(1);
            if (host_rd) begin
               host_pop_fire = 1'b1;
               pop_cnt = (CW'(req) > count) ? NW'(count) : req;
            end
         end else begin
            if (host_wr) push_cnt = (CW'(req) > free_slots) ? NW'(free_slots) : req;
            if (eng_out_ready && count != '0) pop_cnt = NW'(1);
         end
      end
   end
endmodule

// File: rtl/dbf_ptrs.sv
module dbf_ptrs #(
   parameter int DEPTH = 16,
   parameter int NW    = 3,
   parameter int AW    = 4,
   parameter int CW    = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          abort,
   input  logic [NW-1:0] push_cnt,
   input  logic [NW-1:0] pop_cnt,
   output logic [AW-1:0] wptr,
   output logic [AW-1:0] rptr,
   output logic [CW-1:0] count,
   output logic [CW-1:0] count_next
);
   always_comb begin
      if (abort) count_next = '0;
      else       count_next = count + CW'(push_cnt) - CW'(pop_cnt);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (abort) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         wptr  <= wptr + AW'(push_cnt);
         rptr  <= rptr + AW'(pop_cnt);
         count <= count_next;
      end
   end
endmodule

// File: rtl/dbf_store.sv
module dbf_store #(
   parameter int DEPTH = 16,
   parameter int LANES = 4,
   parameter int NW    = 3,
   parameter int AW    = 4
) (
   input  logic               clk,
   input  logic [AW-1:0]      wptr,
   input  logic [AW-1:0]      rptr,
   input  logic [NW-1:0]      push_cnt,
   input  logic               host_src,
   input  logic [8*LANES-1:0] host_wdata,
   input  logic [7:0]         eng_byte,
   output logic [8*LANES-1:0] taps
);
   logic [7:0]    mem   [DEPTH];
   logic [LANES-1:0] we;
   logic [AW-1:0] waddr [LANES];
   logic [7:0]    wbyte [LANES];

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign we[i]    = NW'(i) < push_cnt;
      assign waddr[i] = wptr + AW'(i);
      if (i == 0) begin : g_first
         assign wbyte[i] = host_src ? host_wdata[7:0] : eng_byte;
      end else begin : g_rest
         assign wbyte[i] = host_wdata[8*i +: 8];
      end
      assign taps[8*i +: 8] = mem[rptr + AW'(i)];
   end

   always_ff @(posedge clk) begin
      for (int l = 0; l < LANES; l++) begin
         if (we[l]) mem[waddr[l]] <= wbyte[l];
      end
   end
endmodule

// File: rtl/dbf_flag.sv
module dbf_flag #(
   parameter int DEPTH       = 16,
   parameter int TH_W        = 5,
   parameter int CW          = 5,
   parameter bit DMA_REQ_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            abort,
   input  logic            mode_rd,
   input  logic            dma_en,
   input  logic [TH_W-1:0] thresh,
   input  logic [CW-1:0]   count_next,
   output logic            thr_flag,
   output logic            dma_req
);
   localparam int XW = (CW > TH_W) ? CW : TH_W;

   logic [CW-1:0] avail;
   logic          hit;

   always_comb begin
      avail = mode_rd ? count_next : (CW'(DEPTH) - count_next);
      hit   = XW'(avail) > XW'(thresh);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     thr_flag <= 1'b0;
      else if (abort) thr_flag <= 1'b0;
      else            thr_flag <= hit;
   end

   if (DMA_REQ_REG) begin : g_req_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     dma_req <= 1'b0;
         else if (abort) dma_req <= 1'b0;
         else            dma_req <= hit && dma_en;
      end
   end else begin : g_req_comb
      assign dma_req = thr_flag && dma_en;
   end
endmodule

// File: rtl/dbf_top.sv
module dbf_top #(
   parameter int  LANES       = 4,
   parameter int  DEPTH       = 16,
   parameter int  TH_W        = 5,
   parameter bit  DMA_REQ_REG = 1'b0,
   localparam int DW = 8 * LANES,
   localparam int SW = $clog2($clog2(LANES) + 1),
   localparam int CW = $clog2(DEPTH) + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mode_rd,
   input  logic [TH_W-1:0] thresh,
   input  logic            dma_en,
   input  logic            abort,
   input  logic            host_wr,
   input  logic            host_rd,
   input  logic [SW-1:0]   host_size,
   input  logic [DW-1:0]   host_wdata,
   output logic [DW-1:0]   host_rdata,
   input  logic            eng_in_valid,
   input  logic [7:0]      eng_in_data,
   output logic            eng_in_ready,
   output logic            eng_out_valid,
   output logic [7:0]      eng_out_data,
   input  logic            eng_out_ready,
   output logic [CW-1:0]   level,
   output logic            thr_flag,
   output logic            dma_req
);
   localparam int AW = $clog2(DEPTH);
   localparam int NW = $clog2(LANES + 1);

   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("dbf_top: LANES must be a power of two of at least 2");
   end
   if (DEPTH < LANES || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("dbf_top: DEPTH must be a power of two no smaller than LANES");
   end
   if (TH_W < 1) begin : g_bad_th
      $error("dbf_top: TH_W must be positive");
   end

   logic [NW-1:0] push_cnt;
   logic [NW-1:0] pop_cnt;
   logic          host_src;
   logic          host_pop_fire;
   logic [AW-1:0] wptr;
   logic [AW-1:0] rptr;
   logic [CW-1:0] count;
   logic [CW-1:0] count_next;
   logic [DW-1:0] taps;

   dbf_arb #(.DEPTH(DEPTH), .LANES(LANES), .SW(SW), .NW(NW), .CW(CW)) u_arb (
      .mode_rd       (mode_rd),
      .abort         (abort),
      .host_wr       (host_wr),
      .host_rd       (host_rd),
      .host_size     (host_size),
      .eng_in_valid  (eng_in_valid),
      .eng_out_ready (eng_out_ready),
      .count         (count),
      .push_cnt      (push_cnt),
      .pop_cnt       (pop_cnt),
      .host_src      (host_src),
      .host_pop_fire (host_pop_fire)
   );

   dbf_ptrs #(.DEPTH(DEPTH), .NW(NW), .AW(AW), .CW(CW)) u_ptrs (
      .clk        (clk),
      .rst_n      (rst_n),
      .abort      (abort),
      .push_cnt   (push_cnt),
      .pop_cnt    (pop_cnt),
      .wptr       (wptr),
      .rptr       (rptr),
      .count      (count),
      .count_next (count_next)
   );

   dbf_store #(.DEPTH(DEPTH), .LANES(LANES), .NW(NW), .AW(AW)) u_store (
      .clk        (clk),
      .wptr       (wptr),
      .rptr       (rptr),
      .push_cnt   (push_cnt),
      .host_src   (host_src),
      .host_wdata (host_wdata),
      .eng_byte   (eng_in_data),
      .taps       (taps)
   );

   dbf_flag #(.DEPTH(DEPTH), .TH_W(TH_W), .CW(CW), .DMA_REQ_REG(DMA_REQ_REG)) u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .abort      (abort),
      .mode_rd    (mode_rd),
      .dma_en     (dma_en),
      .thresh     (thresh),
      .count_next (count_next),
      .thr_flag   (thr_flag),
      .dma_req    (dma_req)
   );

   // registered host read data; lanes past the popped count read as zero
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rdata <= '0;
      end else if (abort) begin
         host_rdata <= '0;
      end else if (host_pop_fire) begin
         for (int l = 0; l < LANES; l++) begin
            host_rdata[8*l +: 8] <= (NW'(l) < pop_cnt) ? taps[8*l +: 8] : 8'h00;
         end
      end
   end

   assign eng_out_valid = !mode_rd && (count != '0);
   assign eng_out_data  = taps[7:0];
   assign eng_in_ready  = mode_rd && (count != CW'(DEPTH));
   assign level         = count;
endmodule

// File: rtl/dbf_chk.sv
module dbf_chk #(
   parameter int  LANES       = 4,
   parameter int  DEPTH       = 16,
   parameter int  TH_W        = 5,
   parameter bit  DMA_REQ_REG = 1'b0,
   localparam int DW = 8 * LANES,
   localparam int SW = $clog2($clog2(LANES) + 1),
   localparam int CW = $clog2(DEPTH) + 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            mode_rd,
   input logic [TH_W-1:0] thresh,
   input logic            dma_en,
   input logic            abort,
   input logic            host_wr,
   input logic            host_rd,
   input logic [SW-1:0]   host_size,
   input logic [DW-1:0]   host_wdata,
   input logic [DW-1:0]   host_rdata,
   input logic            eng_in_valid,
   input logic [7:0]      eng_in_data,
   input logic            eng_in_ready,
   input logic            eng_out_valid,
   input logic [7:0]      eng_out_data,
   input logic            eng_out_ready,
   input logic [CW-1:0]   level,
   input logic            thr_flag,
   input logic            dma_req
);
   assert_word_push_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_rd && host_wr && int'(host_size) == 2 && int'(level) <= DEPTH - LANES
       && !eng_out_ready && !abort)
      |=> (int'(level) == int'($past(level)) + LANES));

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(level) <= DEPTH);

   assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_rd && host_rd && level == '0 && !eng_in_valid && !abort)
      |=> (host_rdata == '0 && level == '0));

   assert_flag_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_rd && $past(mode_rd) && $stable(thresh) && !$past(abort))
      |-> (thr_flag == (int'(level) > int'(thresh))));

   assert_ignore_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_rd && host_wr && !host_rd && !eng_in_valid && !abort)
      |=> $stable(level));

   assert_abort_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (level == '0 && !thr_flag && host_rdata == '0));
endmodule

bind dbf_top dbf_chk #(.LANES(LANES), .DEPTH(DEPTH), .TH_W(TH_W), .DMA_REQ_REG(DMA_REQ_REG)) u_chk (.*);

// File: tb/tb_dbf_top.sv
`timescale 1ns/1ps
module tb_dbf_top;
   localparam int LANES = 4;
   localparam int DEPTH = 16;
   localparam int TH_W  = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_rd = 1'b0;
   logic [4:0]  thresh = 5'd3;
   logic        dma_en = 1'b0;
   logic        abort = 1'b0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [1:0]  host_size = 2'd0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        eng_in_valid = 1'b0;
   logic [7:0]  eng_in_data = '0;
   logic        eng_in_ready;
   logic        eng_out_valid;
   logic [7:0]  eng_out_data;
   logic        eng_out_ready = 1'b0;
   logic [4:0]  level;
   logic        thr_flag;
   logic        dma_req;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   logic [7:0] sb[$];

   always #2.5 clk = ~clk;

   dbf_top #(.LANES(LANES), .DEPTH(DEPTH), .TH_W(TH_W)) dut (.*);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      chk(act === exp, req, act, exp);
   endtask

   function automatic int nbytes(input logic [1:0] code);
      return (code >= 2) ? 4 : (1 << code);
   endfunction

   // driver: host push, expected bytes go into the scoreboard
   task automatic host_push(input logic [1:0] code, input logic [31:0] data);
      @(negedge clk);
      host_wr = 1'b1; host_size = code; host_wdata = data;
      for (int i = 0; i < nbytes(code); i++)
         if (sb.size() < DEPTH) sb.push_back(data[8*i +: 8]);
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   // monitor: engine drains bytes and compares with scoreboard
   task automatic eng_drain(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         logic [7:0] e;
         e = sb.pop_front();
         chk_eq({req, " engine byte"}, {24'h0, eng_out_data}, {24'h0, e});
         chk_eq({req, " out valid"}, {31'h0, eng_out_valid}, 32'h1);
         eng_out_ready = 1'b1;
         @(negedge clk);
         eng_out_ready = 1'b0;
      end
   endtask

   task automatic eng_fill(input logic [7:0] b);
      eng_in_valid = 1'b1; eng_in_data = b;
      if (sb.size() < DEPTH) sb.push_back(b);
      @(negedge clk);
      eng_in_valid = 1'b0;
   endtask

   task automatic host_pop(input logic [1:0] code, input string req);
      logic [31:0] e;
      e = '0;
      for (int i = 0; i < nbytes(code); i++)
         if (sb.size() > 0) e[8*i +: 8] = sb.pop_front();
      host_rd = 1'b1; host_size = code;
      @(negedge clk);
      host_rd = 1'b0;
      chk_eq({req, " host pop data"}, host_rdata, e);
      chk_eq({req, " level after pop"}, {27'h0, level}, sb.size());
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk_eq("R11 level", {27'h0, level}, 0);
      chk_eq("R11 flag", {31'h0, thr_flag}, 0);
      chk_eq("R11 dma", {31'h0, dma_req}, 0);
      chk_eq("R11 rdata", host_rdata, 0);
      chk_eq("R11 out valid", {31'h0, eng_out_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_eq("R7 write-dir flag empty", {31'h0, thr_flag}, 1);

      // R1 R2 R3: mixed widths in write direction
      host_push(2'd2, 32'h44332211);
      chk_eq("R1 word level", {27'h0, level}, 4);
      host_push(2'd1, 32'hAAAA6655);
      chk_eq("R1 half level", {27'h0, level}, 6);
      host_push(2'd0, 32'hBBBBBB77);
      chk_eq("R1 byte level", {27'h0, level}, 7);
      host_push(2'd3, 32'h0B0A0908);
      chk_eq("R1 code3 level", {27'h0, level}, 11);
      eng_drain(11, "R2");
      chk_eq("R3 empty valid", {31'h0, eng_out_valid}, 0);

      // R5 R7: fill to the edge
      host_push(2'd2, 32'h03020100);
      host_push(2'd2, 32'h07060504);
      host_push(2'd2, 32'h0B0A0908);
      chk_eq("R7 free4 flag", {31'h0, thr_flag}, 1);
      host_push(2'd0, 32'h0000000C);
      chk_eq("R7 free3 flag", {31'h0, thr_flag}, 0);
      host_push(2'd2, 32'h100F0E0D);
      chk_eq("R5 partial level", {27'h0, level}, 16);
      host_push(2'd2, 32'hDEADBEEF);
      chk_eq("R5 full level", {27'h0, level}, 16);
      eng_drain(16, "R5");

      // R9 write direction ignores host_rd and engine push
      host_push(2'd2, 32'h5A5B5C5D);
      host_rd = 1'b1; host_size = 2'd2;
      @(negedge clk);
      host_rd = 1'b0;
      chk_eq("R9 rdata held", host_rdata, 0);
      chk_eq("R9 level after rd", {27'h0, level}, 4);
      eng_in_valid = 1'b1; eng_in_data = 8'hEE;
      @(negedge clk);
      eng_in_valid = 1'b0;
      chk_eq("R9 level after eng push", {27'h0, level}, 4);
      eng_drain(4, "R9");

      // read direction
      mode_rd = 1'b1;
      @(negedge clk);
      for (int b = 0; b < 3; b++) eng_fill(8'h10 + 8'(b));
      chk_eq("R7 read lvl3 flag", {31'h0, thr_flag}, 0);
      eng_fill(8'h13);
      chk_eq("R7 read lvl4 flag", {31'h0, thr_flag}, 1);
      chk_eq("R8 dma off", {31'h0, dma_req}, 0);
      dma_en = 1'b1;
      #0.1;
      chk_eq("R8 dma on", {31'h0, dma_req}, 1);
      dma_en = 1'b0;
      for (int b = 4; b < 7; b++) eng_fill(8'h10 + 8'(b));
      host_pop(2'd2, "R4 R2 word");
      host_pop(2'd1, "R4 half");
      host_pop(2'd2, "R6 short word");
      host_pop(2'd0, "R6 empty byte");
      chk_eq("R3 in ready", {31'h0, eng_in_ready}, 1);

      // R9 read direction ignores host_wr and engine pop
      eng_fill(8'h20);
      eng_fill(8'h21);
      host_push(2'd2, 32'h99999999);
      void'(sb.pop_back()); void'(sb.pop_back()); void'(sb.pop_back()); void'(sb.pop_back());
      chk_eq("R9 host_wr ignored", {27'h0, level}, 2);
      eng_out_ready = 1'b1;
      @(negedge clk);
      eng_out_ready = 1'b0;
      chk_eq("R9 eng pop ignored", {27'h0, level}, 2);
      chk_eq("R3 out valid read dir", {31'h0, eng_out_valid}, 0);
      host_pop(2'd1, "R9 data intact");

      // R7 threshold zero
      thresh = 5'd0;
      eng_fill(8'h31);
      chk_eq("R7 thr0 flag", {31'h0, thr_flag}, 1);
      host_pop(2'd0, "R7 thr0 pop");
      chk_eq("R7 thr0 empty flag", {31'h0, thr_flag}, 0);
      thresh = 5'd3;

      // R3 R5 R10 fill to full then abort
      for (int b = 0; b < 17; b++) eng_fill(8'h40 + 8'(b));
      chk_eq("R5 read full level", {27'h0, level}, 16);
      chk_eq("R3 in ready full", {31'h0, eng_in_ready}, 0);
      host_pop(2'd2, "R4 full pop");
      abort = 1'b1; eng_in_valid = 1'b1; eng_in_data = 8'h77;
      @(negedge clk);
      abort = 1'b0; eng_in_valid = 1'b0;
      sb.delete();
      chk_eq("R10 level", {27'h0, level}, 0);
      chk_eq("R10 flag", {31'h0, thr_flag}, 0);
      chk_eq("R10 rdata", host_rdata, 0);

      // R10 write direction abort then flag recovers
      mode_rd = 1'b0;
      host_push(2'd2, 32'h12345678);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      sb.delete();
      chk_eq("R10 write level", {27'h0, level}, 0);
      chk_eq("R10 write flag", {31'h0, thr_flag}, 0);
      @(negedge clk);
      chk_eq("R7 flag after abort", {31'h0, thr_flag}, 1);
      chk_eq("R3 valid after abort", {31'h0, eng_out_valid}, 0);

      done = 1;
      finish_run();
   end
endmodule